// File: doc/BRIEF.md
# Coherent Line State Controller

This block tracks the four-state coherence tag (invalid, shared, exclusive, modified) for a small, directly indexed group of lines in one cache. It takes local requests from the cache pipeline (read, write, evict) and snoop requests from other caches (read, invalidate). It decides each line's next state and tells the rest of the cache when a dirty line has to be written back. Data never passes through the block. Moving a line is shown only by handshake pulses: a query to the other caches with its shared/modified reply, a fill-complete pulse, and a writeback strobe.

Only one local miss can be outstanding at a time. The local engine has three states. `LF_IDLE` accepts requests. A read or write that misses moves `LF_IDLE -> LF_QUERY`, and the block holds `qry_valid` until the reply arrives. The reply moves `LF_QUERY -> LF_FILL`. `fill_done` then installs the line and moves `LF_FILL -> LF_IDLE`. Hits, silent upgrades and evictions finish inside `LF_IDLE` in one cycle.

Snoops are handled alongside the local engine. A snoop that targets the index of a pending fill is held off until that fill completes. A `ro_mode` input turns on read-only (instruction cache) operation. In this mode a line can only be S or I.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads invalid (code 0), `loc_ready` is 1, and `qry_valid`, `loc_done`, `snp_resp_valid` and `wb_strobe` are 0.
- R2: A read (op code 0) to an invalid line raises `qry_valid` with `qry_rfo` low in the cycle after acceptance and holds it until `qry_resp_valid`. The line is installed as shared (1) if the reply has `qry_shared` or `qry_modified` set, otherwise as exclusive (2). `loc_done` pulses in the cycle after the `fill_done` edge.
- R3: A write (op code 1) to an invalid or shared line raises `qry_valid` with `qry_rfo` high. After `fill_done` the line is installed as modified (3), whatever the reply flags say.
- R4: A write to an exclusive line moves it to modified with no query. A write to a modified line and a read of any valid line leave the state unchanged. All of these pulse `loc_done` in the cycle after acceptance.
- R5: An accepted snoop read (`snp_inv` low) moves M to S and strobes a writeback of that index. It moves E to S, leaves S as S, and leaves I as I with no writeback.
- R6: An accepted snoop invalidate (`snp_inv` high) moves M to I with a writeback strobe, and moves S or E to I with none.
- R7: In the cycle after a snoop is accepted, `snp_resp_valid` is 1. `snp_hit` is 1 exactly when the line was S or E, and `snp_hitm` is 1 exactly when it was M.
- R8: While a local miss is pending, a snoop to the same index is not accepted (`snp_ready` low) until the fill completes. A snoop to any other index is accepted.
- R9: `loc_ready` is low while a miss is pending and in any cycle in which `snp_valid` is high.
- R10: With `ro_mode` high, every fill is installed as shared. A write request changes no state, issues no query and just pulses `loc_done`.
- R11: An evict (op code 2) of a modified line moves it to I and strobes `wb_strobe` with `wb_idx` equal to that index in the next cycle. Evicting S or E moves the line to I with no strobe. Evicting I has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ro_mode | input | 1 | Read-only (instruction cache) mode |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | 0 read, 1 write, 2 evict |
| loc_idx | input | IW | Local request line index |
| loc_ready | output | 1 | Local request accepted this cycle if valid |
| loc_done | output | 1 | Local request completed (pulse) |
| qry_valid | output | 1 | Query to other caches outstanding |
| qry_rfo | output | 1 | Query is a read-for-ownership |
| qry_resp_valid | input | 1 | Query reply present |
| qry_shared | input | 1 | Another cache holds a clean copy |
| qry_modified | input | 1 | Another cache held a dirty copy |
| fill_done | input | 1 | Line data has arrived (pulse) |
| snp_valid | input | 1 | Snoop request present |
| snp_inv | input | 1 | Snoop is an invalidate (1) or read (0) |
| snp_idx | input | IW | Snoop line index |
| snp_ready | output | 1 | Snoop accepted this cycle if valid |
| snp_resp_valid | output | 1 | Snoop answer valid |
| snp_hit | output | 1 | Snooped line was clean and valid |
| snp_hitm | output | 1 | Snooped line was modified |
| wb_strobe | output | 1 | Writeback of a dirty line required |
| wb_idx | output | IW | Index of the line to write back |
| look_idx | input | IW | Line index to observe |
| look_state | output | 2 | State code of line `look_idx` |

## Verification
The bench drives a snoop at the index of a pending miss and at a second index in the same cycles. A design that checks only for "busy" would stall both snoops. A design that ignores the pending index would let the snoop corrupt the line before the fill writes over it. The bench checks the reply flags on both branches of each transition. A design that fills as E after a modified reply, or that queries the bus on an E write hit, is caught. So is a design that drops the writeback on a snooped M line or strobes one on a clean eviction. Read-only mode is exercised with a write to both a present and an absent line; any state change, or any query, shows up on the ports.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_NOP = 2'd3
    } loc_op_t;

    typedef enum logic [1:0] {
        LF_IDLE  = 2'd0,
        LF_QUERY = 2'd1,
        LF_FILL  = 2'd2
    } lfsm_t;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  line_st_t      a_st,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  line_st_t      b_st,
    input  logic [IW-1:0] ra_idx,
    output line_st_t      ra_st,
    input  logic [IW-1:0] rb_idx,
    output line_st_t      rb_st,
    input  logic [IW-1:0] rc_idx,
    output line_st_t      rc_st
);

    line_st_t mem [LINES];

    // One register per line; the snoop port (b) wins a same-line clash.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= LN_I;
            else if (b_we && b_idx == IW'(g))
                mem[g] <= b_st;
            else if (a_we && a_idx == IW'(g))
                mem[g] <= a_st;
        end
    end

    assign ra_st = mem[ra_idx];
    assign rb_st = mem[rb_idx];
    assign rc_st = mem[rc_idx];

    // R8: the stall keeps a snoop and a fill from hitting one line together
    a_r8_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we) |-> (a_idx != b_idx));

endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
    import mesi_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ro_mode,
    input  logic          loc_valid,
    input  loc_op_t       loc_op,
    input  logic [IW-1:0] loc_idx,
    input  line_st_t      cur_st,
    input  logic          snp_valid,
    input  logic          qry_resp_valid,
    input  logic          qry_shared,
    input  logic          qry_modified,
    input  logic          fill_done,
    output logic          loc_ready,
    output logic          qry_valid,
    output logic          qry_rfo,
    output logic          busy,
    output logic [IW-1:0] pend_idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output line_st_t      wr_st,
    output logic          loc_done,
    output logic          wb_pulse,
    output logic [IW-1:0] wb_idx
);

    lfsm_t         st_q, st_d;
    logic [IW-1:0] pend_q;
    logic          rfo_q;
    line_st_t      fill_q;

    logic          acc, go_miss, go_rfo, hit_done, hit_wr, hit_wb;
    line_st_t      hit_st;

    assign loc_ready = (st_q == LF_IDLE) && !snp_valid;
    assign acc       = loc_valid && loc_ready;

    // Request decode against the line's present state
    always_comb begin
        go_miss  = 1'b0;
        go_rfo   = 1'b0;
        hit_done = 1'b0;
        hit_wr   = 1'b0;
        hit_wb   = 1'b0;
        hit_st   = LN_I;
        if (acc) begin
            unique case (loc_op)
                OP_RD: begin
                    if (cur_st == LN_I) go_miss  = 1'b1;
                    else                hit_done = 1'b1;
                end
                OP_WR: begin
                    if (ro_mode) begin
                        hit_done = 1'b1;
                    end else if (cur_st == LN_I || cur_st == LN_S) begin
                        go_miss = 1'b1;
                        go_rfo  = 1'b1;
                    end else begin
                        hit_done = 1'b1;
                        hit_wr   = (cur_st == LN_E);
                        hit_st   = LN_M;
                    end
                end
                OP_EV: begin
                    hit_done = 1'b1;
                    hit_wr   = (cur_st != LN_I);
                    hit_st   = LN_I;
                    hit_wb   = (cur_st == LN_M);
                end
                default: hit_done = 1'b1;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LF_IDLE:  if (go_miss)        st_d = LF_QUERY;
            LF_QUERY: if (qry_resp_valid) st_d = LF_FILL;
            LF_FILL:  if (fill_done)      st_d = LF_IDLE;
            default:                      st_d = LF_IDLE;
        endcase
    end

    // State register and registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= LF_IDLE;
            pend_q   <= '0;
            rfo_q    <= 1'b0;
            fill_q   <= LN_I;
            loc_done <= 1'b0;
            wb_pulse <= 1'b0;
            wb_idx   <= '0;
        end else begin
            st_q     <= st_d;
            loc_done <= hit_done || (st_q == LF_FILL && fill_done);
            wb_pulse <= hit_wb;
            if (hit_wb) wb_idx <= loc_idx;
            if (go_miss) begin
                pend_q <= loc_idx;
                rfo_q  <= go_rfo;
            end
            if (st_q == LF_QUERY && qry_resp_valid) begin
                if (rfo_q)
                    fill_q <= LN_M;
                else if (ro_mode || qry_shared || qry_modified)
                    fill_q <= LN_S;
                else
                    fill_q <= LN_E;
            end
        end
    end

    // Outputs
    always_comb begin
        qry_valid = (st_q == LF_QUERY);
        qry_rfo   = qry_valid && rfo_q;
        busy      = (st_q != LF_IDLE);
        pend_idx  = pend_q;
        if (st_q == LF_FILL && fill_done) begin
            wr_en  = 1'b1;
            wr_idx = pend_q;
            wr_st  = fill_q;
        end else begin
            wr_en  = hit_wr;
            wr_idx = loc_idx;
            wr_st  = hit_st;
        end
    end

    a_r2_read_miss_query: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && loc_op == OP_RD && cur_st == LN_I)
        |=> (qry_valid && !qry_rfo));

    a_r3_write_miss_rfo: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && loc_op == OP_WR && !ro_mode &&
         (cur_st == LN_I || cur_st == LN_S))
        |=> (qry_valid && qry_rfo));

    a_r4_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && loc_op == OP_WR && !ro_mode && cur_st == LN_E)
        |=> (loc_done && !qry_valid));

    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !loc_ready);

    a_r10_ro_states: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_mode && wr_en) |-> (wr_st == LN_S || wr_st == LN_I));

    a_r11_evict_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready && loc_op == OP_EV && cur_st == LN_M)
        |=> (wb_pulse && wb_idx == $past(loc_idx)));

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snp_valid,
    input  logic          snp_inv,
    input  logic [IW-1:0] snp_idx,
    input  logic          busy,
    input  logic [IW-1:0] pend_idx,
    input  line_st_t      cur_st,
    output logic          snp_ready,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output line_st_t      wr_st,
    output logic          resp_valid,
    output logic          hit,
    output logic          hitm,
    output logic          wb_pulse,
    output logic [IW-1:0] wb_idx
);

    logic     acc;
    line_st_t nxt;

    assign snp_ready = !(busy && pend_idx == snp_idx);
    assign acc       = snp_valid && snp_ready;

    always_comb begin
        unique case (cur_st)
            LN_M:    nxt = snp_inv ? LN_I : LN_S;
            LN_E:    nxt = snp_inv ? LN_I : LN_S;
            LN_S:    nxt = snp_inv ? LN_I : LN_S;
            default: nxt = LN_I;
        endcase
        wr_en  = acc && (nxt != cur_st);
        wr_idx = snp_idx;
        wr_st  = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            hit        <= 1'b0;
            hitm       <= 1'b0;
            wb_pulse   <= 1'b0;
            wb_idx     <= '0;
        end else begin
            resp_valid <= acc;
            hit        <= acc && (cur_st == LN_S || cur_st == LN_E);
            hitm       <= acc && (cur_st == LN_M);
            wb_pulse   <= acc && (cur_st == LN_M);
            if (acc) wb_idx <= snp_idx;
        end
    end

    a_r7_hit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || hitm) |-> (resp_valid && !(hit && hitm)));

    a_r5_dirty_snoop_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && cur_st == LN_M) |=> (hitm && wb_pulse));

    a_r6_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && snp_inv)
        |-> (cur_st == LN_I || (wr_en && wr_st == LN_I)));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int  LINES = 8,
    localparam int IW    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ro_mode,
    input  logic          loc_valid,
    input  logic [1:0]    loc_op,
    input  logic [IW-1:0] loc_idx,
    output logic          loc_ready,
    output logic          loc_done,
    output logic          qry_valid,
    output logic          qry_rfo,
    input  logic          qry_resp_valid,
    input  logic          qry_shared,
    input  logic          qry_modified,
    input  logic          fill_done,
    input  logic          snp_valid,
    input  logic          snp_inv,
    input  logic [IW-1:0] snp_idx,
    output logic          snp_ready,
    output logic          snp_resp_valid,
    output logic          snp_hit,
    output logic          snp_hitm,
    output logic          wb_strobe,
    output logic [IW-1:0] wb_idx,
    input  logic [IW-1:0] look_idx,
    output logic [1:0]    look_state
);

    line_st_t      loc_cur, snp_cur, look_cur;
    logic          l_we, s_we, busy;
    logic [IW-1:0] l_widx, s_widx, pend_idx;
    line_st_t      l_wst, s_wst;
    logic          l_wb, s_wb;
    logic [IW-1:0] l_wbidx, s_wbidx;

    mesi_state_array #(.LINES(LINES), .IW(IW)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_we   (l_we),
        .a_idx  (l_widx),
        .a_st   (l_wst),
        .b_we   (s_we),
        .b_idx  (s_widx),
        .b_st   (s_wst),
        .ra_idx (loc_idx),
        .ra_st  (loc_cur),
        .rb_idx (snp_idx),
        .rb_st  (snp_cur),
        .rc_idx (look_idx),
        .rc_st  (look_cur)
    );

    mesi_local_fsm #(.IW(IW)) u_local (
        .clk            (clk),
        .rst_n          (rst_n),
        .ro_mode        (ro_mode),
        .loc_valid      (loc_valid),
        .loc_op         (loc_op_t'(loc_op)),
        .loc_idx        (loc_idx),
        .cur_st         (loc_cur),
        .snp_valid      (snp_valid),
        .qry_resp_valid (qry_resp_valid),
        .qry_shared     (qry_shared),
        .qry_modified   (qry_modified),
        .fill_done      (fill_done),
        .loc_ready      (loc_ready),
        .qry_valid      (qry_valid),
        .qry_rfo        (qry_rfo),
        .busy           (busy),
        .pend_idx       (pend_idx),
        .wr_en          (l_we),
        .wr_idx         (l_widx),
        .wr_st          (l_wst),
        .loc_done       (loc_done),
        .wb_pulse       (l_wb),
        .wb_idx         (l_wbidx)
    );

    mesi_snoop_unit #(.IW(IW)) u_snoop (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_valid  (snp_valid),
        .snp_inv    (snp_inv),
        .snp_idx    (snp_idx),
        .busy       (busy),
        .pend_idx   (pend_idx),
        .cur_st     (snp_cur),
        .snp_ready  (snp_ready),
        .wr_en      (s_we),
        .wr_idx     (s_widx),
        .wr_st      (s_wst),
        .resp_valid (snp_resp_valid),
        .hit        (snp_hit),
        .hitm       (snp_hitm),
        .wb_pulse   (s_wb),
        .wb_idx     (s_wbidx)
    );

    assign wb_strobe  = l_wb | s_wb;
    assign wb_idx     = s_wb ? s_wbidx : l_wbidx;
    assign look_state = look_cur;

    // R11/R5: evictions and snoops are never accepted together, so strobes never collide
    a_r11_single_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_wb && s_wb));

    // R9: a presented snoop always takes precedence over local requests
    a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !loc_ready);

endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;

    localparam int LINES = 8;
    localparam int I_ = 0, S_ = 1, E_ = 2, M_ = 3;
    localparam int RD = 0, WR = 1, EV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ro_mode = 1'b0;
    logic loc_valid = 1'b0;
    logic [1:0] loc_op = '0;
    logic [2:0] loc_idx = '0;
    logic loc_ready, loc_done, qry_valid, qry_rfo;
    logic qry_resp_valid = 1'b0, qry_shared = 1'b0, qry_modified = 1'b0, fill_done = 1'b0;
    logic snp_valid = 1'b0, snp_inv = 1'b0;
    logic [2:0] snp_idx = '0;
    logic snp_ready, snp_resp_valid, snp_hit, snp_hitm, wb_strobe;
    logic [2:0] wb_idx;
    logic [2:0] probe = '0;
    logic [1:0] look_state;

    int ref_st [LINES];
    int vecs = 0;
    int bad  = 0;

    always #4 clk = ~clk;

    mesi_line_ctrl #(.LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n), .ro_mode(ro_mode),
        .loc_valid(loc_valid), .loc_op(loc_op), .loc_idx(loc_idx),
        .loc_ready(loc_ready), .loc_done(loc_done),
        .qry_valid(qry_valid), .qry_rfo(qry_rfo),
        .qry_resp_valid(qry_resp_valid), .qry_shared(qry_shared),
        .qry_modified(qry_modified), .fill_done(fill_done),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_idx(snp_idx),
        .snp_ready(snp_ready), .snp_resp_valid(snp_resp_valid),
        .snp_hit(snp_hit), .snp_hitm(snp_hitm),
        .wb_strobe(wb_strobe), .wb_idx(wb_idx),
        .look_idx(probe), .look_state(look_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the observed line against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            vecs++;
            if (int'(look_state) != ref_st[probe]) begin
                bad++;
                $display("FAIL line-state tracking (R2 R3 R5 R6 R11) line %0d: got %0d expected %0d",
                         probe, look_state, ref_st[probe]);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_line(input int idx, input int exp, input string tag);
        @(negedge clk);
        probe = 3'(idx);
        #1;
        chk(tag, int'(look_state), exp);
    endtask

    task automatic loc_hit(input int op, input int idx, input int exp_st,
                           input int exp_wb, input string tag);
        loc_valid = 1'b1; loc_op = 2'(op); loc_idx = 3'(idx);
        #1 chk({tag, " ready"}, int'(loc_ready), 1);
        step();
        loc_valid = 1'b0;
        ref_st[idx] = exp_st;
        chk({tag, " done"}, int'(loc_done), 1);
        chk({tag, " wb"}, int'(wb_strobe), exp_wb);
        if (exp_wb != 0) chk({tag, " wb_idx"}, int'(wb_idx), idx);
        chk({tag, " no query"}, int'(qry_valid), 0);
        check_line(idx, exp_st, {tag, " state"});
    endtask

    task automatic loc_miss(input int op, input int idx, input int sh, input int md,
                            input int exp_rfo, input int exp_st, input string tag);
        loc_valid = 1'b1; loc_op = 2'(op); loc_idx = 3'(idx);
        #1 chk({tag, " ready"}, int'(loc_ready), 1);
        step();
        loc_valid = 1'b0;
        chk({tag, " query"}, int'(qry_valid), 1);
        chk({tag, " rfo"}, int'(qry_rfo), exp_rfo);
        chk({tag, " busy ready (R9)"}, int'(loc_ready), 0);
        step();
        chk({tag, " query held"}, int'(qry_valid), 1);
        qry_resp_valid = 1'b1; qry_shared = sh[0]; qry_modified = md[0];
        step();
        qry_resp_valid = 1'b0; qry_shared = 1'b0; qry_modified = 1'b0;
        chk({tag, " query dropped"}, int'(qry_valid), 0);
        chk({tag, " no early done"}, int'(loc_done), 0);
        fill_done = 1'b1;
        step();
        fill_done = 1'b0;
        ref_st[idx] = exp_st;
        chk({tag, " done"}, int'(loc_done), 1);
        check_line(idx, exp_st, {tag, " state"});
    endtask

    task automatic snoop(input int inv, input int idx, input int exp_hit, input int exp_hitm,
                         input int exp_st, input string tag);
        snp_valid = 1'b1; snp_inv = inv[0]; snp_idx = 3'(idx);
        #1 chk({tag, " ready"}, int'(snp_ready), 1);
        step();
        snp_valid = 1'b0;
        ref_st[idx] = exp_st;
        chk({tag, " resp (R7)"}, int'(snp_resp_valid), 1);
        chk({tag, " hit (R7)"}, int'(snp_hit), exp_hit);
        chk({tag, " hitm (R7)"}, int'(snp_hitm), exp_hitm);
        chk({tag, " wb"}, int'(wb_strobe), exp_hitm);
        if (exp_hitm != 0) chk({tag, " wb_idx"}, int'(wb_idx), idx);
        check_line(idx, exp_st, {tag, " state"});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) ref_st[i] = I_;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 loc_ready", int'(loc_ready), 1);
        chk("R1 qry_valid", int'(qry_valid), 0);
        chk("R1 loc_done", int'(loc_done), 0);
        chk("R1 snp_resp_valid", int'(snp_resp_valid), 0);
        chk("R1 wb_strobe", int'(wb_strobe), 0);
        for (int i = 0; i < LINES; i++) check_line(i, I_, "R1 line invalid");

        // R2: read misses with the three reply patterns
        loc_miss(RD, 1, 0, 0, 0, E_, "R2 fill exclusive");
        loc_miss(RD, 2, 1, 0, 0, S_, "R2 fill shared");
        loc_miss(RD, 6, 0, 1, 0, S_, "R2 fill after dirty reply");

        // R4: hits
        loc_hit(WR, 1, M_, 0, "R4 E write upgrade");
        loc_hit(RD, 1, M_, 0, "R4 read hit M");
        loc_hit(WR, 1, M_, 0, "R4 write hit M");
        loc_hit(RD, 6, S_, 0, "R4 read hit S");

        // R3: ownership requests
        loc_miss(WR, 2, 0, 0, 1, M_, "R3 S upgrade via rfo");
        loc_miss(WR, 4, 1, 1, 1, M_, "R3 write miss rfo");

        // R5 / R6: snoops
        snoop(0, 1, 0, 1, S_, "R5 snoop read M");
        snoop(0, 1, 1, 0, S_, "R5 snoop read S");
        snoop(1, 2, 0, 1, I_, "R6 snoop inv M");
        loc_miss(RD, 5, 0, 0, 0, E_, "R2 fill line5");
        snoop(0, 5, 1, 0, S_, "R5 snoop read E");
        snoop(1, 5, 1, 0, I_, "R6 snoop inv S");
        snoop(0, 0, 0, 0, I_, "R5 snoop read I");
        loc_miss(RD, 7, 0, 0, 0, E_, "R2 fill line7");
        snoop(1, 7, 1, 0, I_, "R6 snoop inv E");

        // R11: evictions
        loc_hit(EV, 4, I_, 1, "R11 evict M");
        loc_hit(EV, 6, I_, 0, "R11 evict S");
        loc_hit(EV, 1, I_, 0, "R11 evict S line1");
        loc_hit(EV, 0, I_, 0, "R11 evict I");
        loc_miss(RD, 3, 0, 0, 0, E_, "R2 fill line3");
        loc_hit(EV, 3, I_, 0, "R11 evict E");

        // R8 / R9: snoop stall on a pending fill
        loc_valid = 1'b1; loc_op = 2'(RD); loc_idx = 3'd3;
        #1 chk("R8 setup ready", int'(loc_ready), 1);
        step();
        loc_valid = 1'b0;
        snp_valid = 1'b1; snp_inv = 1'b0; snp_idx = 3'd3;
        #1 chk("R8 same-index snoop stalled", int'(snp_ready), 0);
        chk("R9 busy blocks local", int'(loc_ready), 0);
        step();
        chk("R8 stalled snoop no resp", int'(snp_resp_valid), 0);
        snp_idx = 3'd6;
        qry_resp_valid = 1'b1;
        #1 chk("R8 other-index snoop accepted", int'(snp_ready), 1);
        step();
        qry_resp_valid = 1'b0;
        ref_st[6] = I_;
        chk("R8 other snoop resp", int'(snp_resp_valid), 1);
        chk("R8 other snoop no hit", int'(snp_hit), 0);
        chk("R8 other snoop no wb", int'(wb_strobe), 0);
        snp_idx = 3'd3;
        #1 chk("R8 still stalled in fill", int'(snp_ready), 0);
        fill_done = 1'b1;
        step();
        fill_done = 1'b0;
        ref_st[3] = E_;
        chk("R2 stalled-case done", int'(loc_done), 1);
        chk("R8 stall released", int'(snp_ready), 1);
        chk("R9 snoop presented blocks local", int'(loc_ready), 0);
        step();
        snp_valid = 1'b0;
        ref_st[3] = S_;
        chk("R8 released snoop hit", int'(snp_hit), 1);
        chk("R8 released snoop hitm", int'(snp_hitm), 0);
        check_line(3, S_, "R8 line after release");

        // R10: read-only mode
        ro_mode = 1'b1;
        loc_miss(RD, 0, 0, 0, 0, S_, "R10 ro fill shared");
        loc_hit(WR, 0, S_, 0, "R10 ro write present");
        loc_hit(WR, 4, I_, 0, "R10 ro write absent");
        snoop(1, 0, 1, 0, I_, "R10 ro snoop inv");
        ro_mode = 1'b0;

        repeat (2) step();
        summary();
        $finish;
    end

endmodule